// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits each and returns the full `2*WIDTH`-bit product. The multiplier operand is cut into radix-4 digits. Each digit comes from a three-bit window, and each window shares one bit with the window below it. A recoder turns each digit into three controls: select the multiplicand, select the multiplicand doubled, and negate. A row generator uses these controls to build a partial product. A negated row is formed by bit inversion only. Its +1 is placed as a separate correction bit at the row's base position, and that bit goes into the reduction as an extra operand.

The rows are sign-extended to the product width, aligned two bits apart, and reduced by a chain of carry-save rows to a sum vector and a carry vector. One carry-propagate adder then resolves the pair. The datapath is combinational. A parameter adds an output register with a synchronous active-low reset, or removes it so the product follows the inputs in the same cycle. `WIDTH` must be even and at least 4.

Top module: `booth_mul`

## Requirements
- R1: `product` equals the signed product of `mcand` and `mplier`, both read as two's-complement `WIDTH`-bit values, as a `2*WIDTH`-bit two's-complement value, for every input pair.
- R2: With `REG_OUT`=1, `product` takes the result for the inputs present at a rising clock edge at that edge and holds it until the next edge. With `REG_OUT`=0, `product` follows the inputs combinationally.
- R3: With `REG_OUT`=1, a rising edge with `rst_n` low sets `product` to zero, whatever the operand values.
- R4: Digit i is read from the window of multiplier bits (2i+1, 2i, 2i-1), with bit -1 taken as 0. Windows 000 and 111 give 0. Windows 001 and 010 give +M. Window 011 gives +2M. Window 100 gives -2M. Windows 101 and 110 give -M. No recoder raises the single and double selects together, and none raises negate while selecting zero.
- R5: The result is exact when either operand or both operands equal the most negative value (-2^(WIDTH-1)) or the all-ones pattern (-1). Carries above bit 2*WIDTH-1 are discarded.
- R6: Modulo 2^(2*WIDTH), the final sum vector plus the final carry vector of the carry-save reduction equals the signed product.
- R7: The same structure is exact for a wider instance (`WIDTH`=16, `REG_OUT`=0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier (the recoded operand) |
| product | output | 2*WIDTH | Signed product |

## Verification
The assertions check three properties on every clock. Every recoder's controls are consistent: at most one select is raised, and negate is never raised with a zero selection. The carry-save pair resolves to the signed product of the current operands. The registered output equals the signed product of the previous cycle's operands, and it is zero after a reset edge. The bench scenarios cover what a per-cycle property cannot show: exhaustive coverage of all 65,536 operand pairs at the default width, output latency and hold behaviour, reset overriding live operands, and a random and directed sweep of a wider combinational instance.

// File: rtl/booth_pkg.sv
// Shared types for the radix-4 Booth multiplier.
// Assumes nothing beyond IEEE 1800-2017 packages.
package booth_pkg;

    // Per-digit control bundle emitted by a recoder
    typedef struct packed {
        logic single;   // select multiplicand x1
        logic double;   // select multiplicand x2
        logic negate;   // invert selected row, +1 deferred
    } booth_ctl_t;

endpackage

// File: rtl/booth_recoder.sv
// Turns one overlapping 3-bit multiplier window into select/negate controls.
// Assumes the window is {upper, middle, lower}, where lower is the bit shared
// with the window below (0 for the lowest window).
module booth_recoder
    import booth_pkg::*;
(
    input  logic [2:0]  window,
    output booth_ctl_t  ctl
);

    // Decode the window into a digit in {-2,-1,0,+1,+2}
    always_comb begin
        ctl = '0;
        unique case (window)
            3'b000, 3'b111: ctl = '0;
            3'b001, 3'b010: ctl.single = 1'b1;
            3'b011:         ctl.double = 1'b1;
            3'b100: begin
                ctl.double = 1'b1;
                ctl.negate = 1'b1;
            end
            3'b101, 3'b110: begin
                ctl.single = 1'b1;
                ctl.negate = 1'b1;
            end
            default:        ctl = '0;
        endcase
    end

endmodule

// File: rtl/booth_row_gen.sv
// Forms one partial-product row of WIDTH+2 bits from the multiplicand and a
// digit's controls. A negated row is only inverted here; the +1 that completes
// the two's complement is supplied separately by the caller.
// Assumes single and double are never both raised.
module booth_row_gen
    import booth_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int RW   = WIDTH + 2
) (
    input  logic [WIDTH-1:0] mcand,
    input  booth_ctl_t       ctl,
    output logic [RW-1:0]    row
);

    logic [WIDTH:0] picked;

    // 2:1 choice between x1 (sign-extended) and x2 (shifted), else zero
    always_comb begin
        if (ctl.single)      picked = {mcand[WIDTH-1], mcand};
        else if (ctl.double) picked = {mcand, 1'b0};
        else                 picked = '0;
    end

    // Sign-extend by one bit, then conditionally invert every bit
    assign row = {picked[WIDTH], picked} ^ {RW{ctl.negate}};

endmodule

// File: rtl/csa_row.sv
// One 3:2 carry-save row over W bits. The carry vector is already weighted
// (shifted up by one); the bit leaving the top is dropped.
// Assumes modular arithmetic at width W.
module csa_row #(
    parameter int W = 16
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);

    logic [W-1:0] maj;

    // Bitwise full-adder sum and majority
    always_comb begin
        sum_o   = in_a ^ in_b ^ in_c;
        maj     = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);
        carry_o = {maj[W-2:0], 1'b0};
    end

endmodule

// File: rtl/booth_mul.sv
// Signed radix-4 Booth multiplier: recoders, row generators, a carry-save
// chain that includes the deferred negation bits, and a final adder.
// Assumes WIDTH is even and >= 4. REG_OUT=1 adds an output register with a
// synchronous active-low reset; REG_OUT=0 leaves the path combinational.
module booth_mul
    import booth_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int PW     = 2 * WIDTH,
    localparam int ROWS   = WIDTH / 2,
    localparam int RW     = WIDTH + 2,
    localparam int NOPS   = ROWS + 1,
    localparam int NSTG   = NOPS - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  mcand,
    input  logic [WIDTH-1:0]  mplier,
    output logic [PW-1:0]     product
);

    // Multiplier with an implied 0 below bit 0 and one sign bit on top
    logic [WIDTH+1:0] mp_ext;
    assign mp_ext = {mplier[WIDTH-1], mplier, 1'b0};

    booth_ctl_t       ctl   [ROWS];
    logic [ROWS-1:0]  one_vec;
    logic [ROWS-1:0]  dbl_vec;
    logic [ROWS-1:0]  neg_vec;
    logic [PW-1:0]    ops   [NOPS];
    logic [PW-1:0]    fix_vec;

    for (genvar i = 0; i < ROWS; i++) begin : g_digit
        logic [RW-1:0] row;
        logic [PW-1:0] row_wide;

        booth_recoder u_rec (
            .window (mp_ext[2*i+2 : 2*i]),
            .ctl    (ctl[i])
        );

        booth_row_gen #(.WIDTH(WIDTH)) u_row (
            .mcand (mcand),
            .ctl   (ctl[i]),
            .row   (row)
        );

        // Sign-extend to product width and align to weight 4^i
        assign row_wide = {{(PW-RW){row[RW-1]}}, row};
        assign ops[i]   = row_wide << (2 * i);

        assign one_vec[i] = ctl[i].single;
        assign dbl_vec[i] = ctl[i].double;
        assign neg_vec[i] = ctl[i].negate;
    end

    // Deferred +1 of each negated row sits at that row's base bit 2i
    always_comb begin
        fix_vec = '0;
        for (int i = 0; i < ROWS; i++) fix_vec[2*i] = neg_vec[i];
    end
    assign ops[NOPS-1] = fix_vec;

    // Carry-save chain: fold one extra operand per stage
    logic [PW-1:0] s_chain [NSTG+1];
    logic [PW-1:0] c_chain [NSTG+1];
    assign s_chain[0] = ops[0];
    assign c_chain[0] = ops[1];

    for (genvar k = 0; k < NSTG; k++) begin : g_csa
        csa_row #(.W(PW)) u_csa (
            .in_a    (s_chain[k]),
            .in_b    (c_chain[k]),
            .in_c    (ops[k+2]),
            .sum_o   (s_chain[k+1]),
            .carry_o (c_chain[k+1])
        );
    end

    logic [PW-1:0] tree_sum;
    logic [PW-1:0] tree_carry;
    logic [PW-1:0] prod_comb;
    assign tree_sum   = s_chain[NSTG];
    assign tree_carry = c_chain[NSTG];

    // Single carry-propagate add; overflow past the top bit is dropped
    assign prod_comb = tree_sum + tree_carry;

    if (REG_OUT) begin : g_reg
        logic [PW-1:0] prod_q;
        // Capture the product; clear on synchronous reset
        always_ff @(posedge clk) begin
            if (!rst_n) prod_q <= '0;
            else        prod_q <= prod_comb;
        end
        assign product = prod_q;
    end else begin : g_comb
        assign product = prod_comb;
    end

endmodule

// File: rtl/booth_mul_chk.sv
// Assertion checker for booth_mul, attached by bind below.
// Assumes the internal digit control vectors and final carry-save pair.
module booth_mul_chk #(
    parameter int WIDTH   = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int PW     = 2 * WIDTH,
    localparam int ROWS   = WIDTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  mcand,
    input  logic [WIDTH-1:0]  mplier,
    input  logic [PW-1:0]     product,
    input  logic [ROWS-1:0]   one_vec,
    input  logic [ROWS-1:0]   dbl_vec,
    input  logic [ROWS-1:0]   neg_vec,
    input  logic [PW-1:0]     tree_sum,
    input  logic [PW-1:0]     tree_carry
);

    logic signed [PW-1:0] golden;
    logic [PW-1:0]        pair_total;
    // Behavioural signed product and resolved carry-save pair
    always_comb begin
        golden     = $signed(mcand) * $signed(mplier);
        pair_total = tree_sum + tree_carry;
    end

    // R4
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (one_vec & dbl_vec) == '0);

    // R4
    neg_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_vec & ~(one_vec | dbl_vec)) == '0);

    // R6
    tree_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_total == golden);

    if (REG_OUT) begin : g_reg_chk
        // R1
        reg_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> product == $past(golden));

        // R3
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> product == '0);
    end else begin : g_comb_chk
        // R1
        comb_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
            product == golden);
    end

endmodule

bind booth_mul booth_mul_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_booth_mul_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mcand      (mcand),
    .mplier     (mplier),
    .product    (product),
    .one_vec    (one_vec),
    .dbl_vec    (dbl_vec),
    .neg_vec    (neg_vec),
    .tree_sum   (tree_sum),
    .tree_carry (tree_carry)
);

// File: tb/booth_mul_bench.sv
module booth_mul_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int WW = 16;

    logic clk = 1'b0;
    logic rst_n;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [W-1:0]    a, b;
    logic [2*W-1:0]  p;
    logic [WW-1:0]   wa, wb;
    logic [2*WW-1:0] wp;

    booth_mul #(.WIDTH(W), .REG_OUT(1'b1)) u_booth_mul (
        .clk(clk), .rst_n(rst_n), .mcand(a), .mplier(b), .product(p)
    );

    booth_mul #(.WIDTH(WW), .REG_OUT(1'b0)) u_booth_mul_wide (
        .clk(clk), .rst_n(rst_n), .mcand(wa), .mplier(wb), .product(wp)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    function automatic logic [2*W-1:0] ref8(input logic [W-1:0] x, input logic [W-1:0] y);
        logic signed [2*W-1:0] r;
        r = $signed(x) * $signed(y);
        return r;
    endfunction

    function automatic logic [2*WW-1:0] ref16(input logic [WW-1:0] x, input logic [WW-1:0] y);
        logic signed [2*WW-1:0] r;
        r = $signed(x) * $signed(y);
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Caller sits at a negedge; drive, let one posedge pass, sample at negedge
    task automatic step8(input string req, input logic [W-1:0] x, input logic [W-1:0] y);
        a = x;
        b = y;
        @(negedge clk);
        check(req, 64'(p), 64'(ref8(x, y)));
    endtask

    // R3: reset clears output even with live operands
    task automatic test_reset();
        rst_n = 1'b0;
        a = 8'h00; b = 8'h00;
        repeat (2) @(negedge clk);
        check("R3 reset state", 64'(p), 64'd0);
        a = 8'h7F; b = 8'h80;
        @(negedge clk);
        check("R3 reset with operands", 64'(p), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 after release", 64'(p), 64'(ref8(8'h7F, 8'h80)));
        step8("R3 run", 8'h11, 8'h22);
        rst_n = 1'b0;
        @(negedge clk);
        check("R3 mid-run reset", 64'(p), 64'd0);
        rst_n = 1'b1;
    endtask

    // R2: latency of one edge, hold between edges
    task automatic test_latency();
        step8("R2 prime", 8'h0C, 8'h0D);
        a = 8'hF3; b = 8'h21;
        #1;
        check("R2 no early change", 64'(p), 64'(ref8(8'h0C, 8'h0D)));
        @(negedge clk);
        check("R2 one-edge latency", 64'(p), 64'(ref8(8'hF3, 8'h21)));
        @(negedge clk);
        check("R2 hold", 64'(p), 64'(ref8(8'hF3, 8'h21)));
    endtask

    // R4: multipliers chosen to hit each window value
    task automatic test_digits();
        logic [W-1:0] pats [10] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04,
                                    8'hFF, 8'hFE, 8'h55, 8'hAA, 8'h6C};
        for (int i = 0; i < 10; i++) begin
            step8("R4 digit window", 8'h35, pats[i]);
            step8("R4 digit window neg mcand", 8'hC9, pats[i]);
        end
    endtask

    // R5: most negative, all-ones and neighbours
    task automatic test_extremes();
        logic [W-1:0] v [6] = '{8'h80, 8'hFF, 8'h7F, 8'h00, 8'h01, 8'h81};
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
                step8("R5 extreme operand", v[i], v[j]);
    endtask

    // R1 and R6: every operand pair at the default width
    task automatic test_exhaustive();
        for (int i = 0; i < 256; i++)
            for (int j = 0; j < 256; j++)
                step8("R1/R6 exhaustive", 8'(i), 8'(j));
    endtask

    // R7 and R2: wide combinational instance, directed plus random
    task automatic test_wide();
        logic [WW-1:0] v [5] = '{16'h8000, 16'hFFFF, 16'h7FFF, 16'h0000, 16'h0001};
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++) begin
                wa = v[i]; wb = v[j];
                #1;
                check("R7 wide directed", 64'(wp), 64'(ref16(v[i], v[j])));
            end
        for (int k = 0; k < 3000; k++) begin
            wa = 16'($urandom);
            wb = 16'($urandom);
            #1;
            check("R7 wide random (R2 combinational)", 64'(wp), 64'(ref16(wa, wb)));
        end
    endtask

    initial begin
        rst_n = 1'b0;
        a = '0; b = '0; wa = '0; wb = '0;
        @(negedge clk);
        test_reset();
        test_latency();
        test_digits();
        test_extremes();
        test_exhaustive();
        test_wide();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule